// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date as a set of packed BCD registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A prescaler counts pulses of a 32.768 kHz clock enable and produces one advance per second. The same counter drives a square wave at 1 Hz. Each advance ripples through the fields, and the calendar handles months of different length and February in leap years.

Software sets the time with single-byte writes through a select/data port. The current value of every field is always present on its own output. The hour field can run in 24-hour form, or in 12-hour form with an afternoon flag. Each hour register carries its own format bit. A write to the seconds field also restarts the sub-second count, so the first advance after setting the clock arrives one full second later.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour form), day of week 01, day of month 01, month 01 and year 00, and the 1 Hz output is high.
- R2: The seconds field advances once for every DIV pulses of the clock enable. The 1 Hz output is high while fewer than DIV/2 pulses have been counted since the last second boundary, and low for the remaining pulses.
- R3: Seconds and minutes count 00 to 59 in BCD. Passing 59 returns the field to 00 and advances the next field by one.
- R4: With hour bit 6 at 0, hours count 00 to 23 in BCD. Passing 23 returns the field to 00 and starts a new day.
- R5: With hour bit 6 at 1, bits 4:0 hold the hour 01 to 12 in BCD and bit 5 is the afternoon flag (1 = PM). The sequence is 12 AM, 1 AM … 11 AM, 12 PM, 1 PM … 11 PM, 12 AM. The flag toggles on 11 to 12, and only 11 PM to 12 AM starts a new day. Bit 6 never changes except by a write.
- R6: The day of week (bits 2:0) advances at each new day, from 01 up to 07 and then back to 01.
- R7: The day of month returns to 01 and advances the month after day 30 in April, June, September and November, and after day 31 in January, March, May, July, August, October and December.
- R8: February ends after day 29 when the BCD year is divisible by 4 (including 00), and after day 28 otherwise.
- R9: The month counts 01 to 12. Passing 12 returns it to 01 and advances the year, and the year goes from 99 to 00.
- R10: A write with select 0 (seconds) clears the sub-second count. The next advance comes exactly DIV enable pulses after the write.
- R11: A write to a field (select codes 0 sec, 1 min, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year) shows on its output in the next cycle. It takes priority over an advance arriving in the same cycle, and carries into the other fields still happen in that cycle.
- R12: Bits with no meaning always read 0: bit 7 of seconds, minutes and hours; bits 7:3 of day of week; bits 7:6 of day of month; bits 7:5 of month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write data (packed BCD) |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with format and afternoon bits |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |
| pulse_1hz_o | output | 1 | 1 Hz square wave |

## Verification
The bench targets the ends of every range:
- The last second of a 30-day month, of February in leap and non-leap years, and of year 99. A wrong month-length table leaves the date at 31 or 00, or advances the month one day early. A wrong leap rule skips or repeats 29 February.
- In 12-hour form, the passes 11:59:59 AM, 11:59:59 PM and 12:59:59. A swapped carry starts a new day at noon, toggles the flag at 12 to 1, or produces hour 00 or 13.
- A seconds write in the middle of a second. A prescaler that is not restarted advances too early.
- A write and an advance in the same cycle. A wrong priority loses either the written value or the carry.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef enum logic [2:0] {
      SEL_SEC   = 3'd0,
      SEL_MIN   = 3'd1,
      SEL_HOUR  = 3'd2,
      SEL_WDAY  = 3'd3,
      SEL_MDAY  = 3'd4,
      SEL_MONTH = 3'd5,
      SEL_YEAR  = 3'd6
   } field_sel_e;

   localparam int NUM_FIELDS = 7;

   localparam logic [7:0] MASK_SEC   = 8'h7F;
   localparam logic [7:0] MASK_MIN   = 8'h7F;
   localparam logic [7:0] MASK_HOUR  = 8'h7F;
   localparam logic [7:0] MASK_WDAY  = 8'h07;
   localparam logic [7:0] MASK_MDAY  = 8'h3F;
   localparam logic [7:0] MASK_MONTH = 8'h1F;
   localparam logic [7:0] MASK_YEAR  = 8'hFF;

   // add one to a two-digit packed BCD value
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // leap when the BCD year is a multiple of four
   function automatic logic bcd_leap(input logic [7:0] y);
      logic [7:0] b;
      b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
      return (b[1:0] == 2'b00);
   endfunction

   // last day of a BCD month
   function automatic logic [7:0] bcd_last_day(input logic [4:0] mo, input logic leap);
      logic [7:0] r;
      case (mo)
         5'h02:                      r = leap ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   output logic sec_tick,
   output logic sq_out
);
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;
   localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
   localparam logic [CW-1:0] HALF_V = CW'(HALF);
   localparam bit POW2 = ((1 << CW) == DIV);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("cal_prescaler: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;
   logic          at_last;

   generate
      if (POW2) begin : g_wrap_free
         assign at_last = &cnt;
         assign cnt_nxt = cnt + 1'b1;
      end else begin : g_wrap_cmp
         assign at_last = (cnt == LAST);
         assign cnt_nxt = at_last ? '0 : cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick_en) cnt <= cnt_nxt;
   end

   assign sec_tick = tick_en && at_last;
   assign sq_out   = (cnt < HALF_V);

   // R10
   restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sec_tick);
   // R2
   sq_high_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> sq_out);
   // R2
   sq_rise_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sq_out) |-> ($past(sec_tick) || $past(restart)));

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
   import cal_pkg::*;
#(
   parameter logic [7:0] FLOOR = 8'h00,
   parameter logic [7:0] MASK  = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic [7:0] lim,
   output logic [7:0] q,
   output logic       carry
);
   logic at_top;
   logic [7:0] q_nxt;

   assign at_top = (q == lim);
   assign carry  = inc && at_top;

   always_comb begin
      q_nxt = q;
      if (wr)       q_nxt = wdata & MASK;
      else if (inc) q_nxt = at_top ? FLOOR : (bcd_inc(q) & MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= FLOOR;
      else        q <= q_nxt;
   end

   // R3
   wrap_to_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && !wr) |=> (q == FLOOR));
   // R3
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr) |=> $stable(q));
   // R12
   spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~MASK) == 8'h00);

endmodule

// File: rtl/cal_hour_field.sv
module cal_hour_field
   import cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] q,
   output logic       day_carry
);
   logic       fmt12;
   logic       pm;
   logic [7:0] h12_inc;
   logic [7:0] h24_inc;
   logic [7:0] adv;
   logic       wrap_day;

   assign fmt12   = q[6];
   assign pm      = q[5];
   assign h12_inc = bcd_inc({3'b000, q[4:0]});
   assign h24_inc = bcd_inc({2'b00, q[5:0]});

   always_comb begin
      adv      = q;
      wrap_day = 1'b0;
      if (fmt12) begin
         if (q[4:0] == 5'h11) begin
            adv      = {1'b0, 1'b1, ~pm, 5'h12};
            wrap_day = pm;
         end else if (q[4:0] == 5'h12) begin
            adv = {1'b0, 1'b1, pm, 5'h01};
         end else begin
            adv = {1'b0, 1'b1, pm, h12_inc[4:0]};
         end
      end else begin
         if (q[5:0] == 6'h23) begin
            adv      = 8'h00;
            wrap_day = 1'b1;
         end else begin
            adv = {2'b00, h24_inc[5:0]};
         end
      end
   end

   assign day_carry = inc && wrap_day;

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 8'h00;
      else if (wr)  q <= wdata & MASK_HOUR;
      else if (inc) q <= adv;
   end

   // R5
   format_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (q[6] == $past(q[6])));
   // R4
   midnight_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (day_carry && !wr) |=> (q[6] ? (q[5:0] == 6'h12) : (q[5:0] == 6'h00)));
   // R12
   hour_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q[7] == 1'b0);

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick32k_en,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] mday_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o,
   output logic       pulse_1hz_o
);
   logic [NUM_FIELDS-1:0] wr_hit;

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wr_dec
         assign wr_hit[i] = wr_en && (wr_sel == 3'(i));
      end
   endgenerate

   logic sec_tick;
   logic c_sec, c_min, c_day, c_wday, c_mday, c_month, c_year;
   logic [7:0] mday_last;

   cal_prescaler #(.DIV(DIV)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick32k_en),
      .restart  (wr_hit[SEL_SEC]),
      .sec_tick (sec_tick),
      .sq_out   (pulse_1hz_o)
   );

   cal_bcd_field #(.FLOOR(8'h00), .MASK(MASK_SEC)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(sec_tick), .wr(wr_hit[SEL_SEC]),
      .wdata(wr_data), .lim(8'h59), .q(sec_o), .carry(c_sec)
   );

   cal_bcd_field #(.FLOOR(8'h00), .MASK(MASK_MIN)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(c_sec), .wr(wr_hit[SEL_MIN]),
      .wdata(wr_data), .lim(8'h59), .q(min_o), .carry(c_min)
   );

   cal_hour_field u_hour (
      .clk(clk), .rst_n(rst_n), .inc(c_min), .wr(wr_hit[SEL_HOUR]),
      .wdata(wr_data), .q(hour_o), .day_carry(c_day)
   );

   cal_bcd_field #(.FLOOR(8'h01), .MASK(MASK_WDAY)) u_wday (
      .clk(clk), .rst_n(rst_n), .inc(c_day), .wr(wr_hit[SEL_WDAY]),
      .wdata(wr_data), .lim(8'h07), .q(wday_o), .carry(c_wday)
   );

   assign mday_last = bcd_last_day(month_o[4:0], bcd_leap(year_o));

   cal_bcd_field #(.FLOOR(8'h01), .MASK(MASK_MDAY)) u_mday (
      .clk(clk), .rst_n(rst_n), .inc(c_day), .wr(wr_hit[SEL_MDAY]),
      .wdata(wr_data), .lim(mday_last), .q(mday_o), .carry(c_mday)
   );

   cal_bcd_field #(.FLOOR(8'h01), .MASK(MASK_MONTH)) u_month (
      .clk(clk), .rst_n(rst_n), .inc(c_mday), .wr(wr_hit[SEL_MONTH]),
      .wdata(wr_data), .lim(8'h12), .q(month_o), .carry(c_month)
   );

   cal_bcd_field #(.FLOOR(8'h00), .MASK(MASK_YEAR)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(c_month), .wr(wr_hit[SEL_YEAR]),
      .wdata(wr_data), .lim(8'h99), .q(year_o), .carry(c_year)
   );

   // R6
   wday_moves_on_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_day && !wr_hit[SEL_WDAY]) |=> (wday_o != $past(wday_o)));
   // R7
   month_moves_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_mday && !wr_hit[SEL_MDAY]) |=> (mday_o == 8'h01));
   // R11
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[SEL_MIN] && ((wr_data & MASK_MIN) == wr_data)) |=> (min_o == $past(wr_data)));

endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick32k_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;
   logic       pulse_1hz_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10ns clk = ~clk;

   bcd_calendar #(.DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
      .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o),
      .year_o(year_o), .pulse_1hz_o(pulse_1hz_o)
   );

   // reference model in plain integers
   int m_sec, m_min, m_hr, m_wday, m_mday, m_mon, m_yr;
   bit m_12;

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int days_in(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] hour_reg(int hr, bit f12);
      int h;
      if (!f12) return to_bcd(hr);
      h = hr % 12;
      if (h == 0) h = 12;
      return 8'h40 | ((hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
   endfunction

   task automatic model_tick();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
               m_hr = 0;
               m_wday = (m_wday % 7) + 1;
               m_mday++;
               if (m_mday > days_in(m_mon, m_yr)) begin
                  m_mday = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1;
                     m_yr = (m_yr + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      chk(req, "sec",   sec_o,   to_bcd(m_sec));
      chk(req, "min",   min_o,   to_bcd(m_min));
      chk(req, "hour",  hour_o,  hour_reg(m_hr, m_12));
      chk(req, "wday",  wday_o,  to_bcd(m_wday));
      chk(req, "mday",  mday_o,  to_bcd(m_mday));
      chk(req, "month", month_o, to_bcd(m_mon));
      chk(req, "year",  year_o,  to_bcd(m_yr));
   endtask

   task automatic write_reg(int sel, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic en_step();
      @(negedge clk);
      tick32k_en = 1'b1;
      @(negedge clk);
      tick32k_en = 1'b0;
   endtask

   task automatic one_second();
      for (int i = 0; i < DIV; i++) en_step();
      model_tick();
   endtask

   task automatic load_model();
      write_reg(1, to_bcd(m_min));
      write_reg(2, hour_reg(m_hr, m_12));
      write_reg(3, to_bcd(m_wday));
      write_reg(4, to_bcd(m_mday));
      write_reg(5, to_bcd(m_mon));
      write_reg(6, to_bcd(m_yr));
      write_reg(0, to_bcd(m_sec));
   endtask

   task automatic set_time(int s, int mi, int h, int wd, int md, int mo, int y, bit f12);
      m_sec = s; m_min = mi; m_hr = h; m_wday = wd;
      m_mday = md; m_mon = mo; m_yr = y; m_12 = f12;
      load_model();
   endtask

   task automatic corner(string req, int s, int mi, int h, int wd, int md, int mo, int y, bit f12);
      set_time(s, mi, h, wd, md, mo, y, f12);
      one_second();
      chk_all(req);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      m_sec = 0; m_min = 0; m_hr = 0; m_wday = 1; m_mday = 1; m_mon = 1; m_yr = 0; m_12 = 0;
      chk_all("R1");
      chk("R1", "pulse", {7'd0, pulse_1hz_o}, 8'h01);

      // R2 square wave and tick rate
      en_step(); chk("R2", "pulse ph1", {7'd0, pulse_1hz_o}, 8'h01);
      chk("R2", "sec ph1", sec_o, 8'h00);
      en_step(); chk("R2", "pulse ph2", {7'd0, pulse_1hz_o}, 8'h00);
      en_step(); chk("R2", "pulse ph3", {7'd0, pulse_1hz_o}, 8'h00);
      chk("R2", "sec ph3", sec_o, 8'h00);
      en_step(); model_tick();
      chk("R2", "pulse ph0", {7'd0, pulse_1hz_o}, 8'h01);
      chk("R2", "sec after DIV", sec_o, 8'h01);

      // R12 spare bits read zero
      write_reg(0, 8'hB4); chk("R12", "sec", sec_o, 8'h34);
      write_reg(1, 8'hA1); chk("R12", "min", min_o, 8'h21);
      write_reg(2, 8'h95); chk("R12", "hour", hour_o, 8'h15);
      write_reg(3, 8'hFD); chk("R12", "wday", wday_o, 8'h05);
      write_reg(4, 8'hD7); chk("R12", "mday", mday_o, 8'h17);
      write_reg(5, 8'hE9); chk("R12", "month", month_o, 8'h09);

      // R3 seconds and minutes carries
      corner("R3", 58, 30, 10, 2, 5, 5, 20, 0);
      corner("R3", 59, 30, 10, 2, 5, 5, 20, 0);
      corner("R3", 59, 59, 10, 2, 5, 5, 20, 0);
      // R4 24-hour midnight, R6 day of week wrap
      corner("R4", 59, 59, 23, 3, 5, 5, 20, 0);
      corner("R6", 59, 59, 23, 7, 6, 5, 20, 0);
      // R5 12-hour transitions
      corner("R5", 59, 59, 11, 1, 10, 3, 21, 1);
      corner("R5", 59, 59, 23, 1, 10, 3, 21, 1);
      corner("R5", 59, 59, 12, 1, 10, 3, 21, 1);
      corner("R5", 59, 59, 0, 1, 10, 3, 21, 1);
      corner("R5", 59, 59, 9, 1, 10, 3, 21, 1);
      // R7 month lengths
      corner("R7", 59, 59, 23, 4, 30, 4, 21, 0);
      corner("R7", 59, 59, 23, 4, 30, 1, 21, 0);
      corner("R7", 59, 59, 23, 4, 31, 8, 21, 0);
      corner("R7", 59, 59, 23, 4, 30, 11, 21, 0);
      // R8 February
      corner("R8", 59, 59, 23, 4, 28, 2, 23, 0);
      corner("R8", 59, 59, 23, 4, 28, 2, 24, 0);
      corner("R8", 59, 59, 23, 4, 29, 2, 24, 0);
      corner("R8", 59, 59, 23, 4, 28, 2, 0, 0);
      // R9 year end
      corner("R9", 59, 59, 23, 4, 31, 12, 45, 0);
      corner("R9", 59, 59, 23, 4, 31, 12, 99, 1);

      // R10 seconds write restarts the prescaler
      set_time(5, 20, 8, 2, 3, 3, 22, 0);
      en_step(); en_step();
      write_reg(0, 8'h10); m_sec = 10;
      for (int i = 0; i < DIV - 1; i++) en_step();
      chk("R10", "no early tick", sec_o, 8'h10);
      en_step(); model_tick();
      chk("R10", "tick after DIV", sec_o, 8'h11);

      // R11 write and tick in the same cycle
      set_time(59, 5, 14, 2, 3, 3, 22, 0);
      for (int i = 0; i < DIV - 1; i++) en_step();
      @(negedge clk);
      tick32k_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h20;
      @(negedge clk);
      tick32k_en = 1'b0; wr_en = 1'b0;
      model_tick(); m_min = 20;
      chk_all("R11");

      set_time(59, 10, 14, 2, 3, 3, 22, 0);
      for (int i = 0; i < DIV - 1; i++) en_step();
      @(negedge clk);
      tick32k_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h30;
      @(negedge clk);
      tick32k_en = 1'b0; wr_en = 1'b0;
      model_tick(); m_sec = 30;
      chk_all("R11");

      // random times biased toward carries (R3..R9)
      for (int n = 0; n < 40; n++) begin
         int mo, yr, md, nsec;
         mo = $urandom_range(12, 1);
         yr = $urandom_range(99, 0);
         md = ($urandom_range(1, 0) == 1) ? days_in(mo, yr) : $urandom_range(days_in(mo, yr), 1);
         set_time($urandom_range(59, 55),
                  ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0),
                  ($urandom_range(1, 0) == 1) ? (($urandom_range(1, 0) == 1) ? 23 : 11) : $urandom_range(23, 0),
                  $urandom_range(7, 1), md, mo, yr, 1'($urandom_range(1, 0)));
         nsec = $urandom_range(6, 1);
         for (int k = 0; k < nsec; k++) one_second();
         chk_all("R3-random R7 R8 R9");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(2_000_000ns);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule